// File: doc/BRIEF.md
# Triggered Multi-Event Frame Buffer

This block sits between a set of sensor data lanes and an event FIFO. Each lane hands over 32-bit words with a valid/ready handshake. A shared frame-start marker flags the cycle that carries the first word of every sensor frame. When a trigger arrives and a buffer is free, the block reserves a buffer for that trigger. It then fills the buffer with the next whole frame that the capture engine can take, from one frame-start marker up to the following marker. Finished events leave on a valid/ready output stream in the order their triggers were accepted. Each event starts with a header word and ends with a word flagged as last.

The buffer pool absorbs bursts of triggers that come faster than a frame lasts. A busy output tells the trigger source that every buffer is held. A trigger that arrives while busy is discarded and counted in a saturating counter. Lanes that offer words at the same time are served one word per cycle in rotating order. Words that arrive while no capture is running are accepted and thrown away, so the lanes never stall.

Back-pressure rules: a lane word moves when its `lane_valid_i` bit and the matching `lane_ready_o` bit are both high in the same cycle, and a lane holds its word until then. An output word moves when `out_valid_o` and `out_ready_i` are both high. While `out_ready_i` is low, the block keeps `out_valid_o`, `out_data_o` and `out_last_o` unchanged. Back-pressure on the output never reaches the lanes. It only holds buffers, which in turn raises busy.

Top module: `evbuf_ctrl`

## Requirements
- R1: After reset, `busy_o`, `out_valid_o` and `ovf_count_o` are all zero.
- R2: A trigger taken while `busy_o` is low reserves one buffer. `busy_o` is high from the clock edge that reserves the last free buffer (NUM_BUFS reserved and not yet fully read out) until one is released.
- R3: A trigger taken while `busy_o` is high reserves nothing, and it adds one to `ovf_count_o`. The counter stops at its all-ones value (7 for a 3-bit counter).
- R4: An event's capture starts at the first frame-start cycle strictly after its trigger cycle at which the capture engine is idle or closing a frame. The word consumed in that marker cycle is the event's first word. A trigger in the same cycle as a marker does not use that marker.
- R5: Each cycle, `lane_ready_o` is one-hot on one valid lane, or zero when no lane is valid. The search begins at the lane after the last granted lane and wraps around, and lane 0 goes first after reset.
- R6: Words consumed while no capture is running are dropped and appear in no event.
- R7: Each event on the output is a header word, followed by the stored words in the order they were consumed. The header holds the event sequence number in bits 31:16 and the stored word count in bits 15:0. `out_last_o` is high on the final word, and on the header alone when the count is zero.
- R8: Events leave in trigger-acceptance order. Sequence numbers count accepted triggers from 0 after reset.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_last_o` hold their values.
- R10: A frame longer than BUF_DEPTH words keeps its first BUF_DEPTH words. The header count is BUF_DEPTH, and the extra words are still consumed.
- R11: A buffer is released on the clock edge that transfers its last word. `busy_o` falls on that same edge when the pool was full.
- R12: One frame-start marker both closes the capturing event and starts the next reserved event, so consecutive events take back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger pulse, one per cycle high |
| frame_start_i | input | 1 | Marks the cycle holding a frame's first word |
| lane_valid_i | input | NUM_LANES | Per-lane word valid |
| lane_data_i | input | NUM_LANES*DATA_W | Lane words, lane n in bits n*DATA_W upward |
| lane_ready_o | output | NUM_LANES | Per-lane grant, one-hot or zero |
| busy_o | output | 1 | All buffers held |
| ovf_count_o | output | OVF_W | Saturating count of dropped triggers |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts output word |
| out_data_o | output | DATA_W | Header or frame word |
| out_last_o | output | 1 | Final word of an event |

## Verification
The hardest state to reach is a full pool with every buffer already captured while the output is stalled, followed by a single release. It is reached by holding `out_ready_i` low, firing a burst of triggers until busy rises, and then firing more triggers to push the drop counter into saturation. Back-to-back frame markers then fill every reserved buffer, one marker per event. The bench also lines up a trigger with a closing marker on purpose, to show that the marker in the trigger's own cycle is skipped.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  localparam int SEQ_W = 16;
  localparam int HDR_LEN_W = 16;

  // Header word: sequence number high, stored word count low.
  function automatic logic [31:0] make_header(input logic [SEQ_W-1:0] seq,
                                              input logic [HDR_LEN_W-1:0] len);
    return {seq, len};
  endfunction
endpackage

// File: rtl/evbuf_rr_arb.sv
module evbuf_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int LW = (N > 1) ? $clog2(N) : 1;

  logic [LW-1:0] last_q;
  logic [LW-1:0] win_idx;

  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    win_idx = last_q;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        win_idx  = LW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= LW'(N - 1);
    else if (|req) last_q <= win_idx;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)) else $error("grant not one-hot"); // R5
  AST_GNT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ((gnt & req) != '0)) else $error("request starved"); // R5
  AST_GNT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0)) else $error("grant without request"); // R5
endmodule

// File: rtl/evbuf_store.sv
module evbuf_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_BUFS = 8,
  parameter int DEPTH    = 64
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [$clog2(NUM_BUFS)-1:0] wbuf,
  input  logic [$clog2(DEPTH)-1:0]    waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [$clog2(NUM_BUFS)-1:0] rbuf,
  input  logic [$clog2(DEPTH)-1:0]    raddr,
  output logic [DATA_W-1:0]           rdata
);
  logic [DATA_W-1:0] mem [NUM_BUFS][DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wbuf][waddr] <= wdata;
  end

  assign rdata = mem[rbuf][raddr];
endmodule

// File: rtl/evbuf_drain.sv
module evbuf_drain #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int SEQ_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       have_event,
  input  logic [$clog2(DEPTH+1)-1:0] cur_len,
  input  logic [SEQ_W-1:0]           cur_seq,
  input  logic [DATA_W-1:0]          rdata,
  output logic [$clog2(DEPTH)-1:0]   raddr,
  input  logic                       out_ready_i,
  output logic                       out_valid_o,
  output logic [DATA_W-1:0]          out_data_o,
  output logic                       out_last_o,
  output logic                       pop
);
  import evbuf_pkg::*;
  localparam int LEN_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [LEN_W-1:0] rd_idx_q;
  logic [LEN_W-1:0] rd_prev;
  logic             xfer;

  assign rd_prev     = rd_idx_q - LEN_W'(1);
  assign raddr       = rd_prev[ADDR_W-1:0];
  assign out_valid_o = have_event;
  assign out_last_o  = have_event && (rd_idx_q == cur_len);
  assign out_data_o  = (rd_idx_q == '0)
                     ? make_header(HDR_LEN_W'(cur_seq), HDR_LEN_W'(cur_len))
                     : rdata;
  assign xfer        = out_valid_o && out_ready_i;
  assign pop         = xfer && out_last_o;

  always_ff @(posedge clk) begin
    if (!rst_n)    rd_idx_q <= '0;
    else if (pop)  rd_idx_q <= '0;
    else if (xfer) rd_idx_q <= rd_idx_q + LEN_W'(1);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)))
    else $error("output changed under back-pressure"); // R9
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    have_event |-> (rd_idx_q <= cur_len)) else $error("read past event end"); // R7
endmodule

// File: rtl/evbuf_ctrl.sv
module evbuf_ctrl #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_BUFS  = 8,   // power of two
  parameter int BUF_DEPTH = 64,
  parameter int OVF_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig_i,
  input  logic                          frame_start_i,
  input  logic [NUM_LANES-1:0]          lane_valid_i,
  input  logic [NUM_LANES*DATA_W-1:0]   lane_data_i,
  output logic [NUM_LANES-1:0]          lane_ready_o,
  output logic                          busy_o,
  output logic [OVF_W-1:0]              ovf_count_o,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [DATA_W-1:0]             out_data_o,
  output logic                          out_last_o
);
  import evbuf_pkg::*;
  localparam int IDX_W  = $clog2(NUM_BUFS);
  localparam int PTR_W  = IDX_W + 1;
  localparam int LEN_W  = $clog2(BUF_DEPTH + 1);
  localparam int ADDR_W = $clog2(BUF_DEPTH);
  localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(NUM_BUFS);
  localparam logic [OVF_W-1:0] OVF_MAX  = {OVF_W{1'b1}};

  // Ring pointers: reserve, capture, release all advance in trigger order.
  logic [PTR_W-1:0] alloc_ptr_q, cap_ptr_q, drain_ptr_q, nxt_cap_ptr;
  logic [PTR_W-1:0] occupancy;
  logic             capturing_q;
  logic [LEN_W-1:0] wcnt_q;
  logic [SEQ_W-1:0] seq_cnt_q;
  logic [OVF_W-1:0] ovf_q;
  logic [LEN_W-1:0] len_q [NUM_BUFS];
  logic [SEQ_W-1:0] seq_q [NUM_BUFS];

  logic              trig_ok, frame_close, start_cap, fire, we, pop;
  logic [DATA_W-1:0] wdata, rdata;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] lane_word [NUM_LANES];

  genvar gl;
  generate
    for (gl = 0; gl < NUM_LANES; gl++) begin : g_lane
      assign lane_word[gl] = lane_data_i[gl*DATA_W +: DATA_W];
    end
  endgenerate

  evbuf_rr_arb #(.N(NUM_LANES)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (lane_valid_i),
    .gnt   (lane_ready_o)
  );

  always_comb begin
    wdata = '0;
    for (int l = 0; l < NUM_LANES; l++)
      if (lane_ready_o[l]) wdata = wdata | lane_word[l];
  end

  assign occupancy   = alloc_ptr_q - drain_ptr_q;
  assign busy_o      = (occupancy == FULL_OCC);
  assign trig_ok     = trig_i && !busy_o;
  assign fire        = |lane_ready_o;
  assign frame_close = frame_start_i && capturing_q;
  assign nxt_cap_ptr = cap_ptr_q + (frame_close ? PTR_W'(1) : PTR_W'(0));
  // Uses the registered reserve pointer: a same-cycle trigger is not eligible.
  assign start_cap   = frame_start_i && (alloc_ptr_q != nxt_cap_ptr);
  assign we          = fire && (frame_start_i ? start_cap
                                              : (capturing_q && (wcnt_q < LEN_W'(BUF_DEPTH))));
  assign waddr       = frame_start_i ? '0 : wcnt_q[ADDR_W-1:0];
  assign ovf_count_o = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_ptr_q <= '0;
      cap_ptr_q   <= '0;
      drain_ptr_q <= '0;
      capturing_q <= 1'b0;
      wcnt_q      <= '0;
      seq_cnt_q   <= '0;
      ovf_q       <= '0;
    end else begin
      if (trig_ok) begin
        alloc_ptr_q <= alloc_ptr_q + PTR_W'(1);
        seq_cnt_q   <= seq_cnt_q + SEQ_W'(1);
      end else if (trig_i && ovf_q != OVF_MAX) begin
        ovf_q <= ovf_q + OVF_W'(1);
      end
      cap_ptr_q <= nxt_cap_ptr;
      if (frame_start_i) begin
        capturing_q <= start_cap;
        wcnt_q      <= (start_cap && fire) ? LEN_W'(1) : '0;
      end else if (we) begin
        wcnt_q <= wcnt_q + LEN_W'(1);
      end
      if (pop) drain_ptr_q <= drain_ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BUFS; b++) begin
        len_q[b] <= '0;
        seq_q[b] <= '0;
      end
    end else begin
      if (frame_close) len_q[cap_ptr_q[IDX_W-1:0]] <= wcnt_q;
      if (trig_ok)     seq_q[alloc_ptr_q[IDX_W-1:0]] <= seq_cnt_q;
    end
  end

  evbuf_store #(.DATA_W(DATA_W), .NUM_BUFS(NUM_BUFS), .DEPTH(BUF_DEPTH)) u_store (
    .clk   (clk),
    .we    (we),
    .wbuf  (nxt_cap_ptr[IDX_W-1:0]),
    .waddr (waddr),
    .wdata (wdata),
    .rbuf  (drain_ptr_q[IDX_W-1:0]),
    .raddr (raddr),
    .rdata (rdata)
  );

  evbuf_drain #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH), .SEQ_W(SEQ_W)) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .have_event  (cap_ptr_q != drain_ptr_q),
    .cur_len     (len_q[drain_ptr_q[IDX_W-1:0]]),
    .cur_seq     (seq_q[drain_ptr_q[IDX_W-1:0]]),
    .rdata       (rdata),
    .raddr       (raddr),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .pop         (pop)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= FULL_OCC) else $error("more events than buffers"); // R2
  AST_DROP_KEEPS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && busy_o) |=> (alloc_ptr_q == $past(alloc_ptr_q))) else $error("busy trigger reserved"); // R3
  AST_OVF_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (ovf_q >= $past(ovf_q))) else $error("drop counter went down"); // R3
  AST_CAPTURE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    capturing_q |-> (alloc_ptr_q != cap_ptr_q)) else $error("capture into unreserved buffer"); // R4
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= LEN_W'(BUF_DEPTH)) else $error("fill count past depth"); // R10
  AST_POP_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cap_ptr_q != drain_ptr_q)) else $error("released unfinished buffer"); // R11
endmodule

// File: tb/evbuf_ctrl_test.sv
module evbuf_ctrl_test;
  localparam int NL = 4;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int OW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0, frame_start_i = 1'b0, out_ready_i = 1'b0;
  logic [NL-1:0] lane_valid_i = '0;
  logic [NL*DW-1:0] lane_data_i = '0;
  logic [NL-1:0] lane_ready_o;
  logic busy_o, out_valid_o, out_last_o;
  logic [OW-1:0] ovf_count_o;
  logic [DW-1:0] out_data_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [DW:0] expq [$];

  always #4 clk = ~clk;

  evbuf_ctrl #(.NUM_LANES(NL), .DATA_W(DW), .NUM_BUFS(8), .BUF_DEPTH(DEPTH), .OVF_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .frame_start_i(frame_start_i),
    .lane_valid_i(lane_valid_i), .lane_data_i(lane_data_i), .lane_ready_o(lane_ready_o),
    .busy_o(busy_o), .ovf_count_o(ovf_count_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_last_o(out_last_o)
  );

  task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One input cycle: drive at negedge, hold through the next posedge.
  task automatic cyc(input logic [NL-1:0] vm, input logic [DW-1:0] d, input bit fs, input bit trg);
    @(negedge clk);
    lane_valid_i  = vm;
    lane_data_i   = {NL{d}};
    frame_start_i = fs;
    trig_i        = trg;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    lane_valid_i = '0; frame_start_i = 1'b0; trig_i = 1'b0;
  endtask

  task automatic push_ev(input int seq, input int len, input logic [DW-1:0] base);
    expq.push_back({(len == 0), 16'(seq), 16'(len)});
    for (int k = 0; k < len; k++) expq.push_back({(k == len - 1), base + DW'(k)});
  endtask

  // Drain everything queued; checks each word (R7, R8).
  task automatic drain();
    @(negedge clk);
    out_ready_i = 1'b1;
    while (expq.size() > 0) begin
      logic [DW:0] e;
      e = expq.pop_front();
      #1;
      chk(out_valid_o && out_data_o == e[DW-1:0] && out_last_o == e[DW], "R7/R8 event word",
          {out_last_o, out_data_o}, e);
      @(negedge clk);
    end
    out_ready_i = 1'b0;
  endtask

  localparam int NV = 10;
  localparam logic [7:0] ARB_VEC [NV] = '{
    8'b1111_0001, 8'b1111_0010, 8'b1001_1000, 8'b1001_0001, 8'b0100_0100,
    8'b0000_0000, 8'b1011_1000, 8'b0011_0001, 8'b0110_0010, 8'b0101_0100};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !out_valid_o && ovf_count_o == 0, "R1 reset", {busy_o, out_valid_o, ovf_count_o}, 0);
    rst_n = 1'b1;

    // R5 / R6: arbitration table, no capture running.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      lane_valid_i = ARB_VEC[i][7:4];
      lane_data_i  = {NL{32'hDEAD_0000 + DW'(i)}};
      #1;
      chk(lane_ready_o == ARB_VEC[i][3:0], "R5 round-robin grant", lane_ready_o, ARB_VEC[i][3:0]);
    end
    idle();
    @(negedge clk);
    chk(!out_valid_o, "R6 idle words dropped", out_valid_o, 0);

    // R4, R6, R12: trigger, discarded word, back-to-back frames, same-cycle trigger skip.
    cyc(4'b0000, 0, 0, 1);
    cyc(4'b0001, 32'h111, 0, 0);
    cyc(4'b0001, 32'hA0, 1, 0);
    cyc(4'b0010, 32'hA1, 0, 0);
    cyc(4'b0100, 32'hA2, 0, 1);
    cyc(4'b0001, 32'hB0, 1, 0);
    cyc(4'b1000, 32'hB1, 0, 0);
    cyc(4'b0001, 32'hC0, 1, 1);
    cyc(4'b0001, 32'hC1, 0, 0);
    cyc(4'b0001, 32'hD0, 1, 0);
    cyc(4'b0000, 0, 1, 0);
    idle();
    @(negedge clk);
    chk(out_valid_o && out_data_o == 32'h0000_0003, "R9 header before stall", out_data_o, 32'h3);
    repeat (3) @(negedge clk);
    chk(out_valid_o && out_data_o == 32'h0000_0003 && !out_last_o, "R9 held under stall", out_data_o, 32'h3);
    push_ev(0, 3, 32'hA0);   // R4 first word at marker, R6 0x111 absent
    push_ev(1, 2, 32'hB0);   // R12 one marker closes and opens
    push_ev(2, 1, 32'hD0);   // R4 same-cycle trigger skipped marker with C0
    drain();
    chk(!out_valid_o && !busy_o, "R11 all released", {out_valid_o, busy_o}, 0);

    // R2, R3: fill the pool with output stalled.
    for (int t = 0; t < 8; t++) begin
      cyc(4'b0000, 0, 0, 1);
      idle();
      chk(busy_o == (t == 7), "R2 busy on last buffer", busy_o, (t == 7));
    end
    for (int t = 0; t < 3; t++) cyc(4'b0000, 0, 0, 1);
    idle();
    chk(ovf_count_o == 3, "R3 drop count", ovf_count_o, 3);
    for (int t = 0; t < 7; t++) cyc(4'b0000, 0, 0, 1);
    idle();
    chk(ovf_count_o == 7, "R3 saturation", ovf_count_o, 7);
    for (int k = 0; k < 9; k++) cyc(4'b0100, 32'h200 + DW'(k), 1, 0);
    idle();
    chk(busy_o, "R2 still busy while held", busy_o, 1);

    // R11: release one event, busy falls.
    push_ev(3, 1, 32'h200);
    drain();
    chk(!busy_o, "R11 busy falls after release", busy_o, 0);
    for (int s = 4; s <= 10; s++) push_ev(s, 1, 32'h200 + DW'(s - 3));
    drain();
    chk(!out_valid_o && ovf_count_o == 7, "R8 drained, count kept", {out_valid_o, ovf_count_o}, 7);

    // R10: over-long frame truncated.
    cyc(4'b0000, 0, 0, 1);
    cyc(4'b0001, 32'h300, 1, 0);
    for (int k = 1; k < 11; k++) cyc(4'b0010, 32'h300 + DW'(k), 0, 0);
    cyc(4'b0000, 0, 1, 0);
    idle();
    push_ev(11, DEPTH, 32'h300);
    drain();
    chk(!out_valid_o, "R10 nothing beyond depth", out_valid_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule